// File: doc/BRIEF.md
# Fractional Bit-Rate Enable Generator

This block turns a fast system clock into a one-cycle bit-rate enable for a high-speed UART shifter. A fixed prescaler first divides the system clock by ten to make a base tick (12 MHz from a 120 MHz clock). A programmable divisor then counts base ticks per bit period. The divisor has an integer part and a fraction in eighths. A three-bit accumulator spreads one extra base tick over selected periods, so the average bit period equals the integer plus N/8 base ticks.

Two divisor codes select the fastest rates directly. Integer 0 with fraction 0 fires on every base tick. Integer 1 with fraction 0 fires on every second base tick. Other rates come from the integer-plus-eighths form. The divisor is written with a load strobe. It is held as pending and becomes active only at the next bit boundary, so the period in progress is never cut short. A flag output marks the cycle in which a new divisor takes over.

Top module: `fbg_baud_gen`

## Requirements
- R1: The prescaler makes one base tick every PRESCALE clocks. After reset the default divisor DEF_INT is active, so the first `bit_en` appears exactly PRESCALE*DEF_INT clocks after reset is released (40 with the defaults).
- R2: Code integer 0, fraction 0 selects the full rate: `bit_en` is high once every PRESCALE clocks.
- R3: Code integer 1, fraction 0 selects the half rate: `bit_en` is high once every 2*PRESCALE clocks.
- R4: For integer I ≥ 2 and fraction N (0..7), every bit period lasts PRESCALE*I or PRESCALE*(I+1) clocks. The first period after the divisor takes effect is PRESCALE*I. Any 8 consecutive periods starting there total PRESCALE*(8*I+N) clocks.
- R5: An integer of 0 or 1 with a nonzero fraction is treated as integer 2 with the same fraction.
- R6: A loaded divisor takes effect only at a bit boundary. The period in progress keeps the old length, and `div_applied` is high in the same cycle as the `bit_en` that ends it.
- R7: When several loads arrive before a boundary, only the last one takes effect.
- R8: While reset is high, `bit_en` and `div_applied` are low. Reset clears the prescaler, the period counter, the accumulator and any pending divisor, and it restores the default divisor.
- R9: `bit_en` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_int | input | INT_W | Integer part of the divisor, in base ticks |
| div_frac | input | 3 | Fraction of the divisor, in eighths |
| div_load | input | 1 | One-cycle strobe that captures `div_int` and `div_frac` |
| bit_en | output | 1 | One-cycle bit-rate enable |
| div_applied | output | 1 | One-cycle flag: a loaded divisor took effect |

## Verification
The bench keeps the defaults: PRESCALE 10, INT_W 8 and a default divisor of 4. With these values a single run covers both special codes, the clamped small integers and the full 8-bit integer range up to 255. A fraction's eight-period cycle stays short enough that the bench can measure it in full and compare the total against PRESCALE*(8*I+N). The default divisor of 4 puts the first enable at a known clock count, so reset recovery and the dropping of a pending divisor show directly in the gap between enables.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int FRAC_W = 3;
  typedef logic [FRAC_W-1:0] frac_t;

  // Add the fraction to the accumulator; bit FRAC_W is the stretch carry.
  function automatic logic [FRAC_W:0] frac_step(input frac_t acc, input frac_t n);
    return {1'b0, acc} + {1'b0, n};
  endfunction
endpackage

// File: rtl/fbg_prescale.sv
module fbg_prescale #(
  parameter int PRESCALE = 10
) (
  input  logic clk,
  input  logic rst,
  output logic base_tick
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE == 1) begin : g_pass
      assign base_tick = 1'b1;
    end else begin : g_cnt
      logic [PS_W-1:0] cnt_q;
      localparam logic [PS_W-1:0] LAST = PS_W'(PRESCALE - 1);
      always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + PS_W'(1);
      end
      assign base_tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fbg_div_hold.sv
module fbg_div_hold
  import fbg_pkg::*;
#(
  parameter int INT_W    = 8,
  parameter int DEF_INT  = 4,
  parameter int DEF_FRAC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] ld_int,
  input  frac_t            ld_frac,
  input  logic             ld,
  input  logic             boundary,
  output logic [INT_W-1:0] act_int,
  output frac_t            act_frac,
  output logic             pend,
  output logic             applied
);
  // Map a programmed integer to the tick count used per period.
  function automatic logic [INT_W-1:0] eff_int(input logic [INT_W-1:0] i, input frac_t f);
    if (i == '0 && f == '0) return INT_W'(1);
    else if (i < INT_W'(2))  return INT_W'(2);
    else                     return i;
  endfunction

  localparam logic [INT_W-1:0] RST_INT  = eff_int(INT_W'(DEF_INT), frac_t'(DEF_FRAC));
  localparam frac_t            RST_FRAC = frac_t'(DEF_FRAC);

  logic [INT_W-1:0] pend_int_q;
  frac_t            pend_frac_q;
  logic             pend_q;

  assign applied = boundary & pend_q;
  assign pend    = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_int     <= RST_INT;
      act_frac    <= RST_FRAC;
      pend_int_q  <= '0;
      pend_frac_q <= '0;
      pend_q      <= 1'b0;
    end else begin
      if (applied) begin
        act_int  <= pend_int_q;
        act_frac <= pend_frac_q;
      end
      if (ld) begin
        pend_int_q  <= eff_int(ld_int, ld_frac);
        pend_frac_q <= ld_frac;
        pend_q      <= 1'b1;
      end else if (boundary) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fbg_period.sv
module fbg_period
  import fbg_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             base_tick,
  input  logic [INT_W-1:0] act_int,
  input  frac_t            act_frac,
  input  logic             restart,
  output logic             boundary
);
  logic [INT_W-1:0] tick_q;
  frac_t            acc_q;
  logic [FRAC_W:0]  step;
  logic             stretch;
  logic [INT_W-1:0] last_tick;

  assign step      = frac_step(acc_q, act_frac);
  assign stretch   = step[FRAC_W];
  assign last_tick = act_int - INT_W'(1) + INT_W'(stretch);
  assign boundary  = base_tick && (tick_q == last_tick);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      acc_q  <= '0;
    end else if (base_tick) begin
      if (boundary) begin
        tick_q <= '0;
        acc_q  <= restart ? frac_t'(0) : step[FRAC_W-1:0];
      end else begin
        tick_q <= tick_q + INT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fbg_baud_gen.sv
module fbg_baud_gen
  import fbg_pkg::*;
#(
  parameter int PRESCALE = 10,
  parameter int INT_W    = 8,
  parameter int DEF_INT  = 4,
  parameter int DEF_FRAC = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INT_W-1:0] div_int,
  input  logic [2:0]       div_frac,
  input  logic             div_load,
  output logic             bit_en,
  output logic             div_applied
);
  logic             base_tick;
  logic             boundary;
  logic             pend;
  logic             applied;
  logic [INT_W-1:0] act_int;
  frac_t            act_frac;

  fbg_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .base_tick(base_tick)
  );

  fbg_div_hold #(.INT_W(INT_W), .DEF_INT(DEF_INT), .DEF_FRAC(DEF_FRAC)) u_hold (
    .clk(clk), .rst(rst), .ld_int(div_int), .ld_frac(frac_t'(div_frac)),
    .ld(div_load), .boundary(boundary), .act_int(act_int), .act_frac(act_frac),
    .pend(pend), .applied(applied)
  );

  fbg_period #(.INT_W(INT_W)) u_per (
    .clk(clk), .rst(rst), .base_tick(base_tick), .act_int(act_int),
    .act_frac(act_frac), .restart(applied), .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_en      <= 1'b0;
      div_applied <= 1'b0;
    end else begin
      bit_en      <= boundary;
      div_applied <= applied;
    end
  end
endmodule

// File: rtl/fbg_baud_gen_chk.sv
module fbg_baud_gen_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic div_applied,
  input logic base_tick,
  input logic pend
);
  // R9
  en_single_chk: assert property (@(posedge clk) disable iff (rst) bit_en |=> !bit_en);
  // R1
  en_on_tick_chk: assert property (@(posedge clk) disable iff (rst) bit_en |-> $past(base_tick));
  // R6
  applied_with_en_chk: assert property (@(posedge clk) disable iff (rst) div_applied |-> bit_en);
  // R6
  applied_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(div_applied) |-> $past(pend));
  // R8
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!bit_en && !div_applied));
endmodule

bind fbg_baud_gen fbg_baud_gen_chk u_chk (
  .clk(clk), .rst(rst), .bit_en(bit_en), .div_applied(div_applied),
  .base_tick(base_tick), .pend(pend)
);

// File: tb/fbg_baud_gen_tb.sv
module fbg_baud_gen_tb;
  localparam int PS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_int = '0;
  logic [2:0] div_frac = '0;
  logic       div_load = 1'b0;
  logic       bit_en;
  logic       div_applied;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fbg_baud_gen u_dut (
    .clk(clk), .rst(rst), .div_int(div_int), .div_frac(div_frac),
    .div_load(div_load), .bit_en(bit_en), .div_applied(div_applied)
  );

  typedef struct packed {
    logic [7:0] i;
    logic [2:0] f;
    logic [7:0] ei;   // expected ticks per unstretched period
    logic [3:0] req;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'd0,   3'd0, 8'd1,   4'd2},  // R2 full rate
    '{8'd1,   3'd0, 8'd2,   4'd3},  // R3 half rate
    '{8'd5,   3'd3, 8'd5,   4'd4},  // R4
    '{8'd0,   3'd5, 8'd2,   4'd5},  // R5 clamp from 0
    '{8'd1,   3'd7, 8'd2,   4'd5},  // R5 clamp from 1
    '{8'd12,  3'd4, 8'd12,  4'd4},  // R4
    '{8'd3,   3'd0, 8'd3,   4'd4},  // R4 no fraction
    '{8'd255, 3'd1, 8'd255, 4'd4}   // R4 largest integer
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic next_gap(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!bit_en && gap < 4000);
  endtask

  task automatic load(input int i, input int f);
    div_int  = 8'(i);
    div_frac = 3'(f);
    div_load = 1'b1;
    @(negedge clk);
    div_load = 1'b0;
  endtask

  // Wait for the apply flag; it must coincide with an enable (R6).
  task automatic wait_applied();
    int n = 0;
    while (!div_applied && n < 6000) begin
      @(negedge clk);
      n++;
    end
    check(div_applied && bit_en, "R6 applied with enable", int'(bit_en), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap, sum, ei, f;
    bit okr;

    // R8: outputs quiet in reset
    repeat (3) @(negedge clk);
    check(!bit_en && !div_applied, "R8 reset outputs", int'(bit_en), 0);
    rst = 1'b0;

    // R1: first enable exactly 40 clocks after release
    okr = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (bit_en != (k == 40)) okr = 1'b0;
    end
    check(okr, "R1 first enable at 40", int'(bit_en), 1);
    @(negedge clk);
    check(!bit_en, "R9 single pulse", int'(bit_en), 0);

    // Table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      ei = int'(VECS[v].ei);
      f  = int'(VECS[v].f);
      load(int'(VECS[v].i), f);
      wait_applied();
      next_gap(gap);
      check(gap == PS * ei, $sformatf("R%0d first period v%0d", VECS[v].req, v), gap, PS * ei);
      sum = gap;
      okr = 1'b1;
      for (int p = 1; p < 8; p++) begin
        next_gap(gap);
        sum += gap;
        if (gap != PS * ei && gap != PS * (ei + 1)) okr = 1'b0;
      end
      check(okr, $sformatf("R%0d period lengths v%0d", VECS[v].req, v), gap, PS * ei);
      check(sum == PS * (8 * ei + f), $sformatf("R%0d eight-period total v%0d", VECS[v].req, v),
            sum, PS * (8 * ei + f));
    end

    // R6: load mid-period keeps old period
    load(20, 0);
    wait_applied();
    repeat (30) @(negedge clk);
    load(3, 0);
    next_gap(gap);
    check(gap == 200 - 31, "R6 old period completes", gap, 169);
    check(div_applied, "R6 apply at boundary", int'(div_applied), 1);
    next_gap(gap);
    check(gap == 30, "R6 new period", gap, 30);

    // R7: last load before boundary wins
    load(20, 0);
    wait_applied();
    repeat (5) @(negedge clk);
    load(7, 0);
    repeat (5) @(negedge clk);
    load(9, 0);
    next_gap(gap);
    check(div_applied, "R7 apply flag", int'(div_applied), 1);
    next_gap(gap);
    check(gap == 90, "R7 last load wins", gap, 90);

    // R8: reset mid-run drops pending and restores default
    load(50, 0);
    wait_applied();
    load(3, 0);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!bit_en && !div_applied, "R8 outputs low in reset", int'(bit_en), 0);
    rst = 1'b0;
    next_gap(gap);
    check(gap == 40, "R8 restart first enable", gap, 40);
    next_gap(gap);
    check(gap == 40 && !div_applied, "R8 pending dropped", gap, 40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule